// File: doc/BRIEF.md
# MDIO Management Master Controller

This block is a serial management master for the IEEE 802.3 Clause 22 interface. It sits between a host register bus and one or more external PHY devices. A PHY address and a register address, each 5 bits wide, select one of 32 registers in one of 32 devices. On the PHY side the block drives a management clock. The bidirectional data line appears as three signals: a driven value, an output enable and a sampled input.

The host starts a transaction with a single write to the operation register. That write carries the Clause 22 select bit, the opcode, both addresses and 16 bits of write data. The host then polls the busy bit in the status word. When busy clears after a read, the 16-bit result is available in the status word.

A second register holds the half-period of the management clock, counted in system clocks. With a 125 MHz system clock, the reset value of 25 gives 2.5 MHz.

Top module: `mdio_master`

## Requirements
- R1: After reset the status word is all zero, the management clock is low and the output enable is low.
- R2: Writing to the operation register with `host_sel_i`=0 uses these fields: bit 28 is the Clause 22 select, bits 27:26 the opcode, bits 25:21 the PHY address, bits 20:16 the register address and bits 15:0 the write data. Opcode 01 starts a write frame of 64 bits, each driven with the output enable high. The frame is 32 ones, then 01, the opcode, the PHY address and the register address, then turnaround 10, then the 16 data bits. Every field is sent most significant bit first.
- R3: Opcode 10 starts a read frame. Bit times 0 to 45 are driven as in R2, with opcode 10. The output enable is low for bit times 46 to 63.
- R4: On a read, the data line is sampled on the rising clock edge of bit times 48 to 63, most significant bit first. The result appears in status bits 15:0. It stays there until the next accepted operation starts, which clears it to zero.
- R5: The data line is sampled at bit time 47 of a read. If it is not 0, status bit 18 is set. The bit is cleared when the next operation starts.
- R6: An operation write is rejected if bit 28 is 0 or the opcode is neither 01 nor 10. A rejected write starts no frame, sets status bit 17 and leaves busy low. An accepted operation clears status bit 17.
- R7: Status bit 16 (busy) rises at the clock edge that accepts an operation and falls at the final falling edge of the management clock. Host writes to either register are ignored while busy is set.
- R8: Writing with `host_sel_i`=1 sets the clock half-period N from bits 7:0. Each high and low phase of the management clock then lasts N system clocks. A value of 0 acts as 1. The reset value is 25.
- R9: The data output changes only while the management clock is low.
- R10: While busy is low, the management clock and the output enable stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we_i | input | 1 | Host register write strobe |
| host_sel_i | input | 1 | 0 = operation register, 1 = clock divider register |
| host_wdata_i | input | 32 | Host write data |
| status_o | output | 32 | {13'b0, turnaround error, mode error, busy, read data} |
| mdc_o | output | 1 | Management clock to the PHYs |
| mdo_o | output | 1 | Value driven onto the management data line |
| mdo_oe_o | output | 1 | Output enable for the management data line |
| mdi_i | input | 1 | Sampled management data line |

## Verification
The assertions assume that `mdi_i` is stable around each rising edge of the management clock. They also assume that the host never drops its write strobe in the middle of a cycle. The bench's PHY model therefore changes `mdi_i` only on a falling edge of the management clock. The host drives every write from the falling edge of the system clock, as a single-cycle strobe.

The assertions also rely on the divider value never changing during a frame. The bench deliberately issues divider writes while busy is set. It then confirms that the clock period of that frame matches the old setting.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int TA_HI_IDX  = 46;
    localparam int TA_LO_IDX  = 47;
    localparam int DATA_IDX   = 48;
    localparam int REQ_W      = 1 + 2 + 2 * ADDR_W + DATA_W;

    localparam logic [1:0] OPC_WR = 2'b01;
    localparam logic [1:0] OPC_RD = 2'b10;

    typedef logic [IDX_W-1:0] bit_idx_t;

    // Packed in the same order as host_wdata_i[28:0]
    typedef struct packed {
        logic              c22;
        logic [1:0]        opc;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } op_req_t;

    function automatic logic op_ok(op_req_t r);
        return r.c22 && (r.opc == OPC_WR || r.opc == OPC_RD);
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(op_req_t r);
        logic [1:0]        ta;
        logic [DATA_W-1:0] dat;
        ta  = (r.opc == OPC_RD) ? 2'b11 : 2'b10;
        dat = (r.opc == OPC_RD) ? '1 : r.wdata;
        return {32'hFFFF_FFFF, 2'b01, r.opc, r.phy, r.regad, ta, dat};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             mdc_o,
    output logic             rise_o,
    output logic             fall_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } clk_st_t;

    clk_st_t st_d, st_q;
    logic    at_lim;

    assign at_lim = (st_q.cnt == half_i - DIV_W'(1));

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d = '0;
        end else if (at_lim) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc_o  = st_q.mdc;
    assign rise_o = run_i && at_lim && !st_q.mdc;
    assign fall_o = run_i && at_lim &&  st_q.mdc;

    p_stop_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !mdc_o);

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (st_q.cnt < half_i));

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  op_req_t           req_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              mdi_i,
    output logic              busy_o,
    output logic              mdo_o,
    output logic              oe_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ta_err_o
);

    typedef struct packed {
        logic                  busy;
        logic                  is_rd;
        bit_idx_t              idx;
        logic [FRAME_BITS-1:0] sh;
        logic                  mdo;
        logic                  oe;
        logic [DATA_W-1:0]     rdata;
        logic                  ta_err;
    } frm_st_t;

    frm_st_t  st_d, st_q;
    bit_idx_t nxt_idx;

    assign nxt_idx = st_q.idx + bit_idx_t'(1);

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy   = 1'b1;
                st_d.is_rd  = (req_i.opc == OPC_RD);
                st_d.idx    = '0;
                st_d.sh     = build_frame(req_i);
                st_d.mdo    = st_d.sh[FRAME_BITS-1];
                st_d.oe     = 1'b1;
                st_d.rdata  = '0;
                st_d.ta_err = 1'b0;
            end
        end else begin
            if (rise_i && st_q.is_rd) begin
                if (st_q.idx == bit_idx_t'(TA_LO_IDX))
                    st_d.ta_err = mdi_i;
                if (st_q.idx >= bit_idx_t'(DATA_IDX))
                    st_d.rdata = {st_q.rdata[DATA_W-2:0], mdi_i};
            end
            if (fall_i) begin
                if (st_q.idx == bit_idx_t'(FRAME_BITS - 1)) begin
                    st_d.busy = 1'b0;
                    st_d.oe   = 1'b0;
                    st_d.mdo  = 1'b0;
                end else begin
                    st_d.idx = nxt_idx;
                    st_d.sh  = {st_q.sh[FRAME_BITS-2:0], 1'b0};
                    st_d.mdo = st_q.sh[FRAME_BITS-2];
                    st_d.oe  = !(st_q.is_rd && nxt_idx >= bit_idx_t'(TA_HI_IDX));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o   = st_q.busy;
    assign mdo_o    = st_q.mdo;
    assign oe_o     = st_q.oe;
    assign rdata_o  = st_q.rdata;
    assign ta_err_o = st_q.ta_err;

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> !oe_o);

    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.is_rd && st_q.idx >= bit_idx_t'(TA_HI_IDX)) |-> !oe_o);

    p_hold_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !start_i) |=> $stable(rdata_o));

    p_ta_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && start_i) |=> (busy_o && !ta_err_o && rdata_o == '0));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we_i,
    input  logic        host_sel_i,
    input  logic [31:0] host_wdata_i,
    output logic [31:0] status_o,
    output logic        mdc_o,
    output logic        mdo_o,
    output logic        mdo_oe_o,
    input  logic        mdi_i
);

    localparam logic [DIV_W-1:0] DIV_INIT = (DIV_RST == 0) ? DIV_W'(1) : DIV_W'(DIV_RST);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             mode_err;
    } host_st_t;

    host_st_t          st_d, st_q;
    op_req_t           req;
    logic              busy, accept, start;
    logic              rise, fall;
    logic [DATA_W-1:0] rdata;
    logic              ta_err;
    logic [DIV_W-1:0]  div_wr;

    assign req    = op_req_t'(host_wdata_i[REQ_W-1:0]);
    assign accept = host_we_i && !busy;
    assign start  = accept && !host_sel_i && op_ok(req);
    assign div_wr = host_wdata_i[DIV_W-1:0];

    always_comb begin
        st_d = st_q;
        if (accept) begin
            if (host_sel_i)
                st_d.div = (div_wr == '0) ? DIV_W'(1) : div_wr;
            else
                st_d.mode_err = !op_ok(req);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.div      <= DIV_INIT;
            st_q.mode_err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    mdio_clkgen #(.DIV_W(DIV_W)) i_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy),
        .half_i (st_q.div),
        .mdc_o  (mdc_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    mdio_frame i_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .req_i    (req),
        .rise_i   (rise),
        .fall_i   (fall),
        .mdi_i    (mdi_i),
        .busy_o   (busy),
        .mdo_o    (mdo_o),
        .oe_o     (mdo_oe_o),
        .rdata_o  (rdata),
        .ta_err_o (ta_err)
    );

    assign status_o = {13'd0, ta_err, st_q.mode_err, busy, rdata};

    p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_we_i) |=> ($stable(st_q.div) && $stable(st_q.mode_err)));

    p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !host_sel_i && !op_ok(req)) |=> (!busy && st_q.mode_err));

    p_mdo_on_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdo_o) |-> !mdc_o);

    p_div_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.div != '0);

    p_idle_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc_o);

endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic        sel = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] status;
    logic        mdc, mdo, oe;
    logic        mdi = 1'b1;

    int nchk = 0;
    int nbad = 0;

    logic [63:0] cap_mdo, cap_oe;
    int          k = 0;
    bit          rd_mode = 0;
    bit          ta_val = 0;
    logic [15:0] pdata = '0;
    time         t0 = 0, t1 = 0;

    always #4 clk = ~clk;

    mdio_master i_mdio_master (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_we_i    (we),
        .host_sel_i   (sel),
        .host_wdata_i (wdata),
        .status_o     (status),
        .mdc_o        (mdc),
        .mdo_o        (mdo),
        .mdo_oe_o     (oe),
        .mdi_i        (mdi)
    );

    // PHY model: records each bit at the rising edge, drives read data after the falling edge
    always @(posedge mdc) begin
        if (k < 64) begin
            cap_mdo[63-k] = mdo;
            cap_oe[63-k]  = oe;
        end
        if (k == 0) t0 = $time;
        if (k == 1) t1 = $time;
        k = k + 1;
    end

    always @(negedge mdc) begin
        if (!rd_mode || k < 46) mdi = 1'b1;
        else if (k == 46)       mdi = 1'b1;
        else if (k == 47)       mdi = ta_val;
        else if (k < 64)        mdi = pdata[63-k];
        else                    mdi = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (status[16] && n < 40000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 40000, "R7", "busy never cleared", 64'(n), 64'd40000);
    endtask

    task automatic host_wr(input bit s, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; sel = s; wdata = d;
        @(negedge clk);
        we = 1'b0; sel = 1'b0; wdata = '0;
    endtask

    function automatic logic [31:0] opword(bit c22, logic [1:0] opc, logic [4:0] phy,
                                           logic [4:0] rg, logic [15:0] d);
        return {3'b000, c22, opc, phy, rg, d};
    endfunction

    function automatic logic [63:0] exp_frame(logic [1:0] opc, logic [4:0] phy,
                                              logic [4:0] rg, logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, opc, phy, rg, 2'b10, d};
    endfunction

    task automatic prep(bit rd, bit tav, logic [15:0] pd);
        k = 0; rd_mode = rd; ta_val = tav; pdata = pd;
    endtask

    task automatic do_write(logic [4:0] phy, logic [4:0] rg, logic [15:0] d, int half);
        prep(0, 0, 16'h0);
        host_wr(0, opword(1, 2'b01, phy, rg, d));
        wait_idle();
        chk(cap_mdo == exp_frame(2'b01, phy, rg, d) && k == 64, "R2", "write frame",
            cap_mdo, exp_frame(2'b01, phy, rg, d));
        chk(cap_oe == '1, "R2", "write oe", cap_oe, '1);
        chk((t1 - t0) == time'(16 * half), "R8", "clock period", 64'((t1 - t0) / 8), 64'(2 * half));
    endtask

    task automatic do_read(logic [4:0] phy, logic [4:0] rg, logic [15:0] pd, bit tav);
        logic [63:0] e;
        prep(1, tav, pd);
        host_wr(0, opword(1, 2'b10, phy, rg, 16'h0));
        wait_idle();
        e = exp_frame(2'b10, phy, rg, 16'h0);
        chk(cap_mdo[63:18] == e[63:18] && k == 64, "R3", "read header",
            {18'h0, cap_mdo[63:18]}, {18'h0, e[63:18]});
        chk(cap_oe == {{46{1'b1}}, 18'h0}, "R3", "read oe", cap_oe, {{46{1'b1}}, 18'h0});
        chk(status[15:0] == pd, "R4", "read data", 64'(status[15:0]), 64'(pd));
        chk(status[18] == tav, "R5", "turnaround flag", 64'(status[18]), 64'(tav));
    endtask

    initial begin
        #(8 * 190000);
        nbad++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(status == 32'h0, "R1", "status after reset", 64'(status), 64'h0);
        chk(mdc == 1'b0 && oe == 1'b0, "R1", "mdc/oe after reset", {mdc, oe}, 2'b00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R8 reset divider value 25
        do_write(5'd1, 5'd0, 16'h1234, 25);

        // R8 divider zero acts as one
        host_wr(1, 32'h0);
        do_write(5'd3, 5'd4, 16'hBEEF, 1);

        // R2/R3/R4 sweep at half period 1 over all PHY addresses
        for (int p = 0; p < 32; p++) begin
            do_write(5'(p), 5'((p * 7) % 32), 16'((p * 2731 + 17) % 65536), 1);
            do_read(5'(31 - p), 5'((p * 11) % 32), 16'((p * 4099 + 3) % 65536), 0);
        end

        // R8 other divider settings
        for (int h = 2; h <= 5; h++) begin
            host_wr(1, 32'(h));
            do_write(5'(h), 5'(h + 8), 16'(h * 4369), h);
        end
        host_wr(1, 32'd2);

        // R5 turnaround error, then cleared by the next operation
        do_read(5'd9, 5'd1, 16'hA5C3, 1);
        do_read(5'd9, 5'd2, 16'h0F0F, 0);

        // R4 result held while idle
        repeat (40) @(negedge clk);
        chk(status[15:0] == 16'h0F0F && !status[16], "R4", "held result",
            64'(status[15:0]), 64'h0F0F);
        // R4 cleared when the next operation starts
        prep(0, 0, 16'h0);
        host_wr(0, opword(1, 2'b01, 5'd2, 5'd3, 16'h5555));
        chk(status[15:0] == 16'h0 && status[16], "R4", "result cleared at start",
            64'(status[16:0]), 64'h10000);
        chk(status[16] == 1'b1, "R7", "busy after accept", 64'(status[16]), 64'h1);
        // R7 writes while busy ignored (both registers)
        repeat (5) @(negedge clk);
        host_wr(0, opword(1, 2'b10, 5'd30, 5'd30, 16'hFFFF));
        host_wr(1, 32'd7);
        wait_idle();
        chk(cap_mdo == exp_frame(2'b01, 5'd2, 5'd3, 16'h5555), "R7", "frame unchanged by busy write",
            cap_mdo, exp_frame(2'b01, 5'd2, 5'd3, 16'h5555));
        chk((t1 - t0) == time'(32), "R7", "divider unchanged by busy write",
            64'((t1 - t0) / 8), 64'd4);
        do_write(5'd6, 5'd6, 16'h0001, 2);

        // R6 rejected operations
        prep(0, 0, 16'h0);
        host_wr(0, opword(0, 2'b01, 5'd1, 5'd1, 16'h1111));
        chk(status[17] && !status[16], "R6", "clause select zero", 64'(status[17:16]), 64'h2);
        repeat (20) @(negedge clk);
        chk(k == 0 && mdc == 0 && oe == 0, "R10", "no clock when rejected", 64'(k), 64'h0);
        host_wr(0, opword(1, 2'b00, 5'd1, 5'd1, 16'h1111));
        chk(status[17] && !status[16], "R6", "opcode 00", 64'(status[17:16]), 64'h2);
        host_wr(0, opword(1, 2'b11, 5'd1, 5'd1, 16'h1111));
        chk(status[17] && !status[16], "R6", "opcode 11", 64'(status[17:16]), 64'h2);
        repeat (20) @(negedge clk);
        chk(k == 0, "R6", "no frame after rejects", 64'(k), 64'h0);
        do_write(5'd7, 5'd8, 16'hC0DE, 2);
        chk(status[17] == 1'b0, "R6", "error cleared by accepted op", 64'(status[17]), 64'h0);

        // R9 and R10 idle line
        repeat (10) @(negedge clk);
        chk(mdc == 0 && oe == 0, "R10", "idle after frame", {mdc, oe}, 2'b00);

        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    // R9 bench-side observation: mdo must not change while mdc is high
    logic mdo_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && mdc && mdo !== mdo_prev)
            chk(0, "R9", "mdo changed while mdc high", 64'(mdo), 64'(mdo_prev));
        mdo_prev = mdo;
    end

endmodule